// File: doc/BRIEF.md
# CABAC Bin Decoding Engine

This block is the arithmetic core of a context-adaptive binary arithmetic decoder for H.264 streams. It holds the interval state (a 9-bit range and a 9-bit offset). It decodes one bin per accepted request, in one of three modes: context-coded, equiprobable (bypass) or end-of-slice (terminate). For a context-coded bin, the caller supplies the probability state and the most probable symbol value. The block returns the decoded bin together with the updated context, so that the caller can write the context back to its own storage. Context selection, context initial values and the mapping of bins to syntax values belong to the surrounding logic.

The interval split, the table lookup and the complete renormalization of a bin all take place in the clock cycle in which the request is accepted. A leading-zero count on the new range gives the shift amount directly. The engine fills the vacated offset bits from a 9-bit look-ahead window onto the bitstream. It reports on `bs_used` how many window bits the stream source must drop at that clock edge.

Requests use a valid/ready handshake. A request is taken when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` is low in any of these cases:
- the engine has not been initialized since reset;
- `init` is high;
- the stream window is not valid;
- a previous result is still waiting for its consumer.

A result sits in a one-deep output register. It stays unchanged until `rsp_ready` is seen high. A new request may be taken in the same cycle that the old result leaves. `init` is a plain control pin: it is acted on in any cycle in which the window is valid.

Top module: `cabac_bin_engine`

## Requirements
- R1: After reset `rsp_valid`, `req_ready` and `bs_used` are 0. No request is accepted and no result appears until the first initialization.
- R2: In a cycle with `init` and `bs_valid` both high, `bs_used` is 9 and `req_ready` is 0. At that edge the range becomes 510 and the offset becomes `bs_bits`.
- R3: Mode 2'b00 (regular) computes rLPS from a 64x4 table. The row is the 6-bit state and the column is range[7:6]. The range then becomes range-rLPS. If offset >= range, the bin is the inverse of the MPS, the offset drops by that range and the range becomes rLPS. Otherwise the bin equals the MPS.
- R4: After a regular bin the returned state follows the LPS transition table when the bin is the LPS. It is min(state+1, 62) when the bin is the MPS, and state 63 is held. The returned MPS value flips only for an LPS decoded at state 0.
- R5: Mode 2'b01 (bypass) shifts the offset left by one and takes one new bit. It returns 1 and subtracts the range when the result is >= range, and returns 0 otherwise. The range is unchanged and exactly one bit is used. The returned state and MPS value echo the request.
- R6: Mode 2'b10 or 2'b11 (terminate) reduces the range by 2. It returns 1, with no renormalization and 0 bits used, when offset >= the reduced range. Otherwise it returns 0 and renormalizes. The returned state and MPS value echo the request.
- R7: After a regular bin or a terminate-0 bin, the range and the offset shift left together until range bit 8 is set, all in the accepting cycle. `bs_used` equals the shift count. The new offset LSBs come from the window, where `bs_bits[8]` is the next stream bit.
- R8: A result appears on the cycle after its request is accepted. Results keep request order. A result is held stable while `rsp_ready` is low.
- R9: While `bs_valid` is low, `req_ready` and `bs_used` are 0 and the interval state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Start of slice: reload the interval state from the stream |
| req_valid | input | 1 | Bin request valid |
| req_ready | output | 1 | Engine can take a request |
| req_mode | input | 2 | 00 regular, 01 bypass, 1x terminate |
| req_state | input | 6 | Probability state index of the context |
| req_mps | input | 1 | MPS value of the context |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_bin | output | 1 | Decoded bin |
| rsp_state | output | 6 | Updated probability state |
| rsp_mps | output | 1 | Updated MPS value |
| bs_valid | input | 1 | Stream window holds at least 9 valid bits |
| bs_bits | input | 9 | Next stream bits, bit 8 first |
| bs_used | output | 4 | Bits the stream source drops at this edge |

## Verification
The bench compares the engine against a bit-serial reference: a loop that renormalizes one bit at a time and looks up probability rows for a chosen set of states.

Regular bins run over states 0, 5, 20, 40 and 62 with both MPS values. State 0 shows whether the LPS flip of the MPS value happens. State 62 shows whether the MPS transition saturates. The low-probability rows produce shifts of up to six bits, which expose errors in the shift count or in the fill of the window bits.

Bypass and terminate bins are mixed in at random under random back-pressure. A forced near-full offset at slice start drives the terminate-1 path, which must consume no bits. A stalled window and requests issued before initialization must show no acceptance. Every bit count is checked at its edge, and a single wrong count would shift the rest of the stream out of step with the reference.

// File: rtl/cabac_eng_pkg.sv
package cabac_eng_pkg;
  localparam int STATE_W    = 6;
  localparam int RANGE_W    = 9;
  localparam int LPS_W      = 8;
  localparam int QCOLS      = 4;
  localparam int USED_W     = $clog2(RANGE_W + 1);
  localparam int INIT_RANGE = 510;
  localparam int MPS_CAP    = 62;
  localparam int TERM_DEC   = 2;

  typedef enum logic [1:0] {
    MODE_REGULAR  = 2'b00,
    MODE_BYPASS   = 2'b01,
    MODE_TERM     = 2'b10,
    MODE_TERM_ALT = 2'b11
  } bin_mode_e;
endpackage

// File: rtl/cabac_prob_rom.sv
module cabac_prob_rom
  import cabac_eng_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  input  logic [1:0]         qidx,
  output logic [LPS_W-1:0]   rlps,
  output logic [STATE_W-1:0] next_lps,
  output logic [STATE_W-1:0] next_mps
);
  localparam int ROW_W = STATE_W + QCOLS * LPS_W;
  logic [ROW_W-1:0] row;

  // each row: {next state after LPS, rLPS for q=0, 1, 2, 3}
  always_comb begin
    case (state)
      6'd0:  row = {6'd0,  8'd128, 8'd176, 8'd208, 8'd240};
      6'd1:  row = {6'd0,  8'd128, 8'd167, 8'd197, 8'd227};
      6'd2:  row = {6'd1,  8'd128, 8'd158, 8'd187, 8'd216};
      6'd3:  row = {6'd2,  8'd123, 8'd150, 8'd178, 8'd205};
      6'd4:  row = {6'd2,  8'd116, 8'd142, 8'd169, 8'd195};
      6'd5:  row = {6'd4,  8'd111, 8'd135, 8'd160, 8'd185};
      6'd6:  row = {6'd4,  8'd105, 8'd128, 8'd152, 8'd175};
      6'd7:  row = {6'd5,  8'd100, 8'd122, 8'd144, 8'd166};
      6'd8:  row = {6'd6,  8'd95,  8'd116, 8'd137, 8'd158};
      6'd9:  row = {6'd7,  8'd90,  8'd110, 8'd130, 8'd150};
      6'd10: row = {6'd8,  8'd85,  8'd104, 8'd123, 8'd142};
      6'd11: row = {6'd9,  8'd81,  8'd99,  8'd117, 8'd135};
      6'd12: row = {6'd9,  8'd77,  8'd94,  8'd111, 8'd128};
      6'd13: row = {6'd11, 8'd73,  8'd89,  8'd105, 8'd122};
      6'd14: row = {6'd11, 8'd69,  8'd85,  8'd100, 8'd116};
      6'd15: row = {6'd12, 8'd66,  8'd80,  8'd95,  8'd110};
      6'd16: row = {6'd13, 8'd62,  8'd76,  8'd90,  8'd104};
      6'd17: row = {6'd13, 8'd59,  8'd72,  8'd86,  8'd99};
      6'd18: row = {6'd15, 8'd56,  8'd69,  8'd81,  8'd94};
      6'd19: row = {6'd15, 8'd53,  8'd65,  8'd77,  8'd89};
      6'd20: row = {6'd16, 8'd51,  8'd62,  8'd73,  8'd85};
      6'd21: row = {6'd16, 8'd48,  8'd59,  8'd69,  8'd80};
      6'd22: row = {6'd18, 8'd46,  8'd56,  8'd66,  8'd76};
      6'd23: row = {6'd18, 8'd43,  8'd53,  8'd63,  8'd72};
      6'd24: row = {6'd19, 8'd41,  8'd50,  8'd59,  8'd69};
      6'd25: row = {6'd19, 8'd39,  8'd48,  8'd56,  8'd65};
      6'd26: row = {6'd21, 8'd37,  8'd45,  8'd54,  8'd62};
      6'd27: row = {6'd21, 8'd35,  8'd43,  8'd51,  8'd59};
      6'd28: row = {6'd22, 8'd33,  8'd41,  8'd48,  8'd56};
      6'd29: row = {6'd22, 8'd32,  8'd39,  8'd46,  8'd53};
      6'd30: row = {6'd23, 8'd30,  8'd37,  8'd43,  8'd50};
      6'd31: row = {6'd24, 8'd29,  8'd35,  8'd41,  8'd48};
      6'd32: row = {6'd24, 8'd27,  8'd33,  8'd39,  8'd45};
      6'd33: row = {6'd25, 8'd26,  8'd31,  8'd37,  8'd43};
      6'd34: row = {6'd26, 8'd24,  8'd30,  8'd35,  8'd41};
      6'd35: row = {6'd26, 8'd23,  8'd28,  8'd33,  8'd39};
      6'd36: row = {6'd27, 8'd22,  8'd27,  8'd32,  8'd37};
      6'd37: row = {6'd27, 8'd21,  8'd26,  8'd30,  8'd35};
      6'd38: row = {6'd28, 8'd20,  8'd24,  8'd29,  8'd33};
      6'd39: row = {6'd29, 8'd19,  8'd23,  8'd27,  8'd31};
      6'd40: row = {6'd29, 8'd18,  8'd22,  8'd26,  8'd30};
      6'd41: row = {6'd30, 8'd17,  8'd21,  8'd25,  8'd28};
      6'd42: row = {6'd30, 8'd16,  8'd20,  8'd23,  8'd27};
      6'd43: row = {6'd30, 8'd15,  8'd19,  8'd22,  8'd25};
      6'd44: row = {6'd31, 8'd14,  8'd18,  8'd21,  8'd24};
      6'd45: row = {6'd32, 8'd14,  8'd17,  8'd20,  8'd23};
      6'd46: row = {6'd32, 8'd13,  8'd16,  8'd19,  8'd22};
      6'd47: row = {6'd33, 8'd12,  8'd15,  8'd18,  8'd21};
      6'd48: row = {6'd33, 8'd12,  8'd14,  8'd17,  8'd20};
      6'd49: row = {6'd33, 8'd11,  8'd14,  8'd16,  8'd19};
      6'd50: row = {6'd34, 8'd11,  8'd13,  8'd15,  8'd18};
      6'd51: row = {6'd34, 8'd10,  8'd12,  8'd15,  8'd17};
      6'd52: row = {6'd35, 8'd10,  8'd12,  8'd14,  8'd16};
      6'd53: row = {6'd35, 8'd9,   8'd11,  8'd13,  8'd15};
      6'd54: row = {6'd35, 8'd9,   8'd11,  8'd12,  8'd14};
      6'd55: row = {6'd36, 8'd8,   8'd10,  8'd12,  8'd14};
      6'd56: row = {6'd36, 8'd8,   8'd9,   8'd11,  8'd13};
      6'd57: row = {6'd36, 8'd7,   8'd9,   8'd11,  8'd12};
      6'd58: row = {6'd37, 8'd7,   8'd9,   8'd10,  8'd12};
      6'd59: row = {6'd37, 8'd7,   8'd8,   8'd10,  8'd11};
      6'd60: row = {6'd37, 8'd6,   8'd8,   8'd9,   8'd11};
      6'd61: row = {6'd38, 8'd6,   8'd7,   8'd9,   8'd10};
      6'd62: row = {6'd38, 8'd6,   8'd7,   8'd8,   8'd9};
      default: row = {6'd63, 8'd2, 8'd2,   8'd2,   8'd2};
    endcase
  end

  always_comb begin
    rlps     = row[LPS_W*(QCOLS-1-int'(qidx)) +: LPS_W];
    next_lps = row[ROW_W-1 -: STATE_W];
    next_mps = (int'(state) >= MPS_CAP) ? state : state + STATE_W'(1);
  end
endmodule

// File: rtl/cabac_lzc.sv
module cabac_lzc #(
  parameter int W  = 9,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  logic hit;
  always_comb begin
    count = '0;
    hit   = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (vec[i]) hit = 1'b1;
        else        count = count + CW'(1);
      end
    end
  end
endmodule

// File: rtl/cabac_bin_core.sv
module cabac_bin_core
  import cabac_eng_pkg::*;
(
  input  logic [1:0]         mode,
  input  logic [RANGE_W-1:0] rng,
  input  logic [RANGE_W-1:0] off,
  input  logic [STATE_W-1:0] state,
  input  logic               mps,
  input  logic [RANGE_W-1:0] win,
  output logic               bin,
  output logic [STATE_W-1:0] nstate,
  output logic               nmps,
  output logic [RANGE_W-1:0] nrng,
  output logic [RANGE_W-1:0] noff,
  output logic [USED_W-1:0]  used
);
  logic [LPS_W-1:0]     rlps;
  logic [STATE_W-1:0]   st_lps, st_mps;
  logic [RANGE_W-1:0]   r_mps, r_term, rn_rng, rn_off;
  logic                 is_lps, term_hit;
  logic [USED_W-1:0]    lz;
  logic [USED_W-1:0]    sh;
  logic [2*RANGE_W-1:0] cat;
  logic [RANGE_W:0]     byp_off;
  logic                 byp_hit;

  cabac_prob_rom u_rom (
    .state(state), .qidx(rng[LPS_W-1 -: 2]),
    .rlps(rlps), .next_lps(st_lps), .next_mps(st_mps)
  );

  always_comb begin
    r_mps    = rng - {1'b0, rlps};
    is_lps   = off >= r_mps;
    r_term   = rng - RANGE_W'(TERM_DEC);
    term_hit = off >= r_term;
    if (mode == MODE_REGULAR) begin
      rn_rng = is_lps ? {1'b0, rlps} : r_mps;
      rn_off = is_lps ? off - r_mps : off;
    end else begin
      rn_rng = r_term;
      rn_off = off;
    end
  end

  cabac_lzc #(.W(RANGE_W), .CW(USED_W)) u_lzc (.vec(rn_rng), .count(lz));

  always_comb begin
    byp_off = {off, win[RANGE_W-1]};
    byp_hit = byp_off >= {1'b0, rng};
    sh      = (mode != MODE_REGULAR && term_hit) ? '0 : lz;
    cat     = {rn_off, win} << sh;
    nstate  = state;
    nmps    = mps;
    case (mode)
      MODE_REGULAR: begin
        bin    = is_lps ? ~mps : mps;
        nstate = is_lps ? st_lps : st_mps;
        nmps   = (is_lps && state == '0) ? ~mps : mps;
        nrng   = rn_rng << sh;
        noff   = cat[2*RANGE_W-1 -: RANGE_W];
        used   = sh;
      end
      MODE_BYPASS: begin
        bin    = byp_hit;
        nrng   = rng;
        noff   = byp_hit ? RANGE_W'(byp_off - {1'b0, rng}) : byp_off[RANGE_W-1:0];
        used   = USED_W'(1);
      end
      default: begin
        bin    = term_hit;
        nrng   = rn_rng << sh;
        noff   = cat[2*RANGE_W-1 -: RANGE_W];
        used   = sh;
      end
    endcase
  end
endmodule

// File: rtl/cabac_bin_engine.sv
module cabac_bin_engine
  import cabac_eng_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_mode,
  input  logic [STATE_W-1:0] req_state,
  input  logic               req_mps,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_bin,
  output logic [STATE_W-1:0] rsp_state,
  output logic               rsp_mps,
  input  logic               bs_valid,
  input  logic [RANGE_W-1:0] bs_bits,
  output logic [USED_W-1:0]  bs_used
);
  logic [RANGE_W-1:0] rng_q, off_q, c_rng, c_off;
  logic               armed_q, c_bin, c_mps;
  logic [STATE_W-1:0] c_state;
  logic [USED_W-1:0]  c_used;
  logic               init_fire, fire;

  cabac_bin_core u_core (
    .mode(req_mode), .rng(rng_q), .off(off_q), .state(req_state), .mps(req_mps),
    .win(bs_bits), .bin(c_bin), .nstate(c_state), .nmps(c_mps),
    .nrng(c_rng), .noff(c_off), .used(c_used)
  );

  always_comb begin
    init_fire = init && bs_valid;
    req_ready = armed_q && !init && bs_valid && (!rsp_valid || rsp_ready);
    fire      = req_valid && req_ready;
    if (init_fire) bs_used = USED_W'(RANGE_W);
    else if (fire) bs_used = c_used;
    else           bs_used = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng_q   <= RANGE_W'(INIT_RANGE);
      off_q   <= '0;
      armed_q <= 1'b0;
    end else if (init_fire) begin
      rng_q   <= RANGE_W'(INIT_RANGE);
      off_q   <= bs_bits;
      armed_q <= 1'b1;
    end else if (fire) begin
      rng_q   <= c_rng;
      off_q   <= c_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_bin   <= 1'b0;
      rsp_state <= '0;
      rsp_mps   <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_bin   <= c_bin;
      rsp_state <= c_state;
      rsp_mps   <= c_mps;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R2
  init_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_fire |=> (rng_q == RANGE_W'(INIT_RANGE)));

  // R7
  range_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !init && req_mode != MODE_BYPASS && rng_q[RANGE_W-1] && off_q < rng_q
     && !(req_mode != MODE_REGULAR && c_bin)) |=> rng_q[RANGE_W-1]);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable({rsp_bin, rsp_state, rsp_mps})));

  // R1
  no_early_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !rsp_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bs_valid |=> ($stable(rng_q) && $stable(off_q)));
endmodule

// File: tb/cabac_bin_engine_test.sv
module cabac_bin_engine_test;
  localparam int SLEN = 8192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init = 1'b0, req_valid = 1'b0, req_ready, req_mps = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic [5:0] req_state = '0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_bin, rsp_mps;
  logic [5:0] rsp_state;
  logic bs_valid = 1'b1;
  logic [8:0] bs_bits;
  logic [3:0] bs_used;

  always #2 clk = ~clk;

  cabac_bin_engine uut (
    .clk(clk), .rst_n(rst_n), .init(init), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_state(req_state), .req_mps(req_mps),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_bin(rsp_bin),
    .rsp_state(rsp_state), .rsp_mps(rsp_mps),
    .bs_valid(bs_valid), .bs_bits(bs_bits), .bs_used(bs_used)
  );

  int errs = 0, checks = 0;
  logic sbit [SLEN];
  int feed_ptr = 0;
  int m_ptr = 0, m_rng = 510, m_off = 0;
  logic [31:0] seed = 32'h1357_9bdf;
  logic bp_en = 1'b0;

  typedef struct packed { logic [1:0] mode; logic bin; logic [5:0] st; logic mps; } exp_t;
  exp_t exp_q[$];

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  always_comb
    for (int i = 0; i < 9; i++)
      bs_bits[8-i] = (feed_ptr + i < SLEN) ? sbit[feed_ptr + i] : 1'b0;

  always @(posedge clk) if (rst_n) feed_ptr <= feed_ptr + int'(bs_used);

  always @(posedge clk) begin
    #1;
    rsp_ready = bp_en ? rnd()[3] : 1'b1;
  end

  function automatic int ref_rlps(input int st, input int q);
    int r[4];
    case (st)
      0:  r = '{128, 176, 208, 240};
      5:  r = '{111, 135, 160, 185};
      20: r = '{51, 62, 73, 85};
      40: r = '{18, 22, 26, 30};
      default: r = '{6, 7, 8, 9};
    endcase
    return r[q];
  endfunction

  function automatic int ref_next_lps(input int st);
    case (st)
      0: return 0;  5: return 4;  20: return 16;  40: return 29;
      default: return 38;
    endcase
  endfunction

  function automatic int next_bit();
    int b = int'(sbit[m_ptr]);
    m_ptr++;
    return b;
  endfunction

  task automatic model(input logic [1:0] m, input int st, input logic mps,
                       output exp_t e, output int used);
    int rl;
    e.mode = m; e.st = 6'(st); e.mps = mps; used = 0;
    if (m == 2'b00) begin
      rl = ref_rlps(st, (m_rng >> 6) & 3);
      m_rng = m_rng - rl;
      if (m_off >= m_rng) begin
        e.bin = ~mps; m_off = m_off - m_rng; m_rng = rl;
        if (st == 0) e.mps = ~mps;
        e.st = 6'(ref_next_lps(st));
      end else begin
        e.bin = mps;
        e.st = 6'((st >= 62) ? st : st + 1);
      end
      while (m_rng < 256) begin
        m_rng = m_rng * 2; m_off = m_off * 2 + next_bit(); used++;
      end
    end else if (m == 2'b01) begin
      m_off = m_off * 2 + next_bit(); used = 1;
      e.bin = (m_off >= m_rng);
      if (e.bin) m_off = m_off - m_rng;
    end else begin
      m_rng = m_rng - 2;
      e.bin = (m_off >= m_rng);
      if (!e.bin)
        while (m_rng < 256) begin
          m_rng = m_rng * 2; m_off = m_off * 2 + next_bit(); used++;
        end
    end
  endtask

  task automatic do_init(input logic force_low);
    @(negedge clk);
    if (force_low) sbit[m_ptr] = 1'b0;
    init = 1'b1;
    #1;
    chk(bs_used == 4'd9, "R2 init bit count", int'(bs_used), 9);
    chk(!req_ready, "R2 ready during init", int'(req_ready), 0);
    m_off = 0;
    for (int i = 0; i < 9; i++) m_off = m_off * 2 + next_bit();
    m_rng = 510;
    @(posedge clk);
    #1 init = 1'b0;
  endtask

  task automatic do_req(input logic [1:0] m, input int st, input logic mps);
    exp_t e;
    int used;
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_state = 6'(st); req_mps = mps;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    model(m, st, mps, e, used);
    exp_q.push_back(e);
    if (m == 2'b00) chk(int'(bs_used) == used, "R7 regular shift count", int'(bs_used), used);
    else if (m == 2'b01) chk(int'(bs_used) == used, "R5 bypass bit count", int'(bs_used), used);
    else chk(int'(bs_used) == used, "R6 terminate bit count", int'(bs_used), used);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  logic held = 1'b0;
  logic [7:0] held_val;
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (held && rsp_valid)
        chk({rsp_bin, rsp_state, rsp_mps} == held_val, "R8 held result stable",
            int'({rsp_bin, rsp_state, rsp_mps}), int'(held_val));
      if (rsp_valid && !rsp_ready) begin
        held = 1'b1; held_val = {rsp_bin, rsp_state, rsp_mps};
      end else held = 1'b0;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected result", 1, 0);
        else begin
          e = exp_q.pop_front();
          case (e.mode)
            2'b00: begin
              chk(rsp_bin == e.bin, "R3 regular bin", int'(rsp_bin), int'(e.bin));
              chk({rsp_state, rsp_mps} == {e.st, e.mps}, "R4 context update",
                  int'({rsp_state, rsp_mps}), int'({e.st, e.mps}));
            end
            2'b01: begin
              chk(rsp_bin == e.bin, "R5 bypass bin", int'(rsp_bin), int'(e.bin));
              chk({rsp_state, rsp_mps} == {e.st, e.mps}, "R5 bypass echo",
                  int'({rsp_state, rsp_mps}), int'({e.st, e.mps}));
            end
            default: begin
              chk(rsp_bin == e.bin, "R6 terminate bin", int'(rsp_bin), int'(e.bin));
              chk({rsp_state, rsp_mps} == {e.st, e.mps}, "R6 terminate echo",
                  int'({rsp_state, rsp_mps}), int'({e.st, e.mps}));
            end
          endcase
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  int states[5] = '{0, 5, 20, 40, 62};

  initial begin
    for (int i = 0; i < SLEN; i++) sbit[i] = rnd()[7];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid, "R1 reset rsp_valid", int'(rsp_valid), 0);
    chk(!req_ready, "R1 reset req_ready", int'(req_ready), 0);
    chk(bs_used == 4'd0, "R1 reset bs_used", int'(bs_used), 0);
    req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1 chk(!req_ready && bs_used == 4'd0, "R1 no accept before init", int'(req_ready), 0);
      @(negedge clk);
    end
    chk(!rsp_valid, "R1 no result before init", int'(rsp_valid), 0);
    req_valid = 1'b0;

    do_init(1'b1);
    for (int i = 0; i < 40; i++) do_req(2'b00, states[i % 5], logic'(i / 5 % 2));

    bp_en = 1'b1;
    for (int i = 0; i < 150; i++) begin
      logic [31:0] r = rnd();
      case (r[2:0])
        3'd0, 3'd1: do_req(2'b01, 9, r[5]);
        3'd2:       do_req({1'b1, r[6]}, 33, r[5]);
        default:    do_req(2'b00, states[int'(r[10:8]) % 5], r[5]);
      endcase
    end

    @(negedge clk);
    bs_valid = 1'b0; req_valid = 1'b1; req_mode = 2'b00; req_state = 6'd5; req_mps = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1 chk(!req_ready, "R9 stalled ready", int'(req_ready), 0);
      chk(bs_used == 4'd0, "R9 stalled bit count", int'(bs_used), 0);
      @(negedge clk);
    end
    bs_valid = 1'b1; req_valid = 1'b0;
    for (int i = 0; i < 10; i++) do_req(2'b00, states[i % 5], 1'b1);

    bp_en = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 9; i++) sbit[m_ptr + i] = (i < 7);
    do_init(1'b0);
    do_req(2'b10, 12, 1'b1);
    do_init(1'b1);
    for (int i = 0; i < 20; i++) do_req((i % 4 == 3) ? 2'b01 : 2'b00, states[(i * 3) % 5], logic'(i % 2));

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);
    chk(feed_ptr == m_ptr, "R7 total bits consumed", feed_ptr, m_ptr);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule